// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter with Hold

This block is a four-bit binary counter that advances on the falling transitions of a slow, unrelated count clock, while all of its flops run on one fast system clock. The count clock is first synchronized, and its high-to-low transitions are then detected as single-cycle events. A direction input picks incrementing or decrementing, and an active-low enable freezes the value without clearing it. An active-low load copies a parallel data word into the counter whenever it is low, whatever the count clock is doing.

A terminal-count flag marks the last state of the current direction. A gated, active-low ripple output pulses once per full cycle of sixteen counts, so that the next counter in a chain can use it as its enable. The counter wraps modulo 16 in both directions.

Top module: `updown_preset_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0, and `q` stays 0 after reset is released until a load or a count occurs.
- R2: With `load_n` high, `en_n` low and `dir` = 0 (up), each high-to-low transition of `cnt_clk` adds one to `q`. The new value appears after the third rising edge of `clk` that samples `cnt_clk` low, counting the first edge that sees the low level.
- R3: With `load_n` high, `en_n` low and `dir` = 1 (down), each such transition subtracts one from `q`, with the same latency as in R2.
- R4: Counting wraps modulo 16: counting up from 15 gives 0, and counting down from 0 gives 15.
- R5: While `load_n` is low, each rising edge of `clk` loads `din` into `q`. This happens regardless of `cnt_clk` and takes priority over counting.
- R6: While `en_n` is high and `load_n` is high, `q` holds its value through any count-clock activity. Once `en_n` returns low, counting continues from the held value.
- R7: `tc` is 1 exactly when `dir` = 0 and `q` = 15, or when `dir` = 1 and `q` = 0.
- R8: `rco_n` is 0 exactly when `en_n` is low, `tc` is 1 and the count clock is low, where the count-clock level is the one sampled two `clk` cycles earlier.
- R9: `q` does not change on a rising transition of `cnt_clk`, and it does not change between falling transitions unless a load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all flops are clocked on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clk | input | 1 | Count clock, asynchronous to `clk`; counts on its falling edges |
| en_n | input | 1 | Active-low count enable; high holds the count |
| dir | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Parallel load data |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal-count flag for the current direction |
| rco_n | output | 1 | Active-low ripple pulse used to enable the next stage |

## Verification
The hardest case to reach is a counter that sits at its terminal value while the enable is low and the count clock is low. Only in that state does `rco_n` pulse, and a wrap immediately takes the counter out of it again. The stimulus reaches it in two ways. Directed sequences load 14 or 1 and then apply slow count-clock pulses across the boundary in each direction. Random phases then flip the direction and the enable while the counter is near the ends, and they occasionally assert load on the same cycle that a falling edge is detected, which exercises the priority of load over counting.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/updown_edge_sync.sv
module updown_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_lvl <= 1'b0;
    else        last_lvl <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign fall_o  = last_lvl & ~chain[STAGES-1];
endmodule

// File: rtl/updown_count_core.sv
module updown_count_core
  import updown_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_n,
  input  logic             dir,
  input  logic             step_evt,
  output logic [WIDTH-1:0] q
);
  function automatic logic [WIDTH-1:0] next_val(input logic [WIDTH-1:0] cur,
                                                input logic            down);
    logic [WIDTH-1:0] r;
    if (down == DIR_DOWN) r = cur - {{(WIDTH-1){1'b0}}, 1'b1};
    else                  r = cur + {{(WIDTH-1){1'b0}}, 1'b1};
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (!load_n)          q <= din;
    else if (!en_n && step_evt) q <= next_val(q, dir);
  end
endmodule

// File: rtl/updown_term_detect.sv
module updown_term_detect
  import updown_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             dir,
  input  logic             en_n,
  input  logic             clk_lvl,
  output logic             tc,
  output logic             rco_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  always_comb begin
    if (dir == DIR_DOWN) tc = (q == BOT_VAL);
    else                 tc = (q == TOP_VAL);
  end

  assign rco_n = ~(~en_n & tc & ~clk_lvl);
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
  import updown_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clk,
  input  logic             en_n,
  input  logic             dir,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc,
  output logic             rco_n
);
  logic fall_evt;
  logic cclk_lvl;

  updown_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cnt_clk),
    .level_o (cclk_lvl),
    .fall_o  (fall_evt)
  );

  updown_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .din      (din),
    .en_n     (en_n),
    .dir      (dir),
    .step_evt (fall_evt),
    .q        (q)
  );

  updown_term_detect #(.WIDTH(WIDTH)) u_term (
    .q       (q),
    .dir     (dir),
    .en_n    (en_n),
    .clk_lvl (cclk_lvl),
    .tc      (tc),
    .rco_n   (rco_n)
  );
endmodule

// File: rtl/updown_preset_counter_chk.sv
module updown_preset_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_n,
  input logic             dir,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             tc,
  input logic             rco_n,
  input logic             fall_evt
);
  // R5
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din));

  // R6
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_n) |=> $stable(q));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !en_n && fall_evt && !dir) |=> q == ($past(q) + 1'b1));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !en_n && fall_evt && dir) |=> q == ($past(q) - 1'b1));

  // R9
  quiet_between_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !fall_evt) |=> $stable(q));

  // R7
  tc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (dir ? (q == '0) : (q == '1)));

  // R8
  ripple_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rco_n |-> (tc && !en_n));
endmodule

bind updown_preset_counter updown_preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_n     (en_n),
  .dir      (dir),
  .load_n   (load_n),
  .din      (din),
  .q        (q),
  .tc       (tc),
  .rco_n    (rco_n),
  .fall_evt (fall_evt)
);

// File: tb/updown_preset_counter_tb.sv
`timescale 1ns/1ps
module updown_preset_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_clk = 1'b0;
  logic       en_n = 1'b0;
  logic       dir = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic       tc;
  logic       rco_n;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  updown_preset_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .en_n(en_n), .dir(dir),
    .load_n(load_n), .din(din), .q(q), .tc(tc), .rco_n(rco_n)
  );

  // Expected model built from R1..R9: history of count-clock samples
  logic [3:0] exp_q;
  logic       h1, h2, h3;   // samples taken 1, 2, 3 edges back
  string      q_tag;

  function automatic logic [3:0] bump(input logic [3:0] v, input logic down);
    return down ? 4'((v + 4'd15) & 4'hF) : 4'((v + 4'd1) & 4'hF);
  endfunction

  function automatic logic want_tc(input logic [3:0] v, input logic down);
    return down ? (v == 4'd0) : (v == 4'd15);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 4'd0; h1 <= 1'b0; h2 <= 1'b0; h3 <= 1'b0; q_tag <= "R1";
    end else begin
      // third edge seeing low: sampled low two edges back, high three back
      if (!load_n) begin
        exp_q <= din; q_tag <= "R5";
      end else if (!h2 && h3 && !en_n) begin
        exp_q <= bump(exp_q, dir);
        if (want_tc(exp_q, dir)) q_tag <= "R4";
        else q_tag <= dir ? "R3" : "R2";
      end else if (!h2 && h3) begin
        q_tag <= "R6";
      end else begin
        q_tag <= "R9";
      end
      h3 <= h2; h2 <= h1; h1 <= cnt_clk;
    end
  end

  task automatic check_now();
    logic e_tc, e_rco;
    e_tc  = want_tc(exp_q, dir);
    e_rco = ~(~en_n & e_tc & ~h2);
    n_chk++;
    if (q !== exp_q) begin
      n_bad++;
      $display("FAIL %s: q=%0d expected %0d at cycle %0d", q_tag, q, exp_q, cyc);
    end
    n_chk++;
    if (tc !== e_tc) begin
      n_bad++;
      $display("FAIL R7: tc=%0b expected %0b at cycle %0d", tc, e_tc, cyc);
    end
    n_chk++;
    if (rco_n !== e_rco) begin
      n_bad++;
      $display("FAIL R8: rco_n=%0b expected %0b at cycle %0d", rco_n, e_rco, cyc);
    end
  endtask

  // Check every cycle away from the active edge, once out of reset
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) check_now();
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_clk = 1'b1; idle(4);
      cnt_clk = 1'b0; idle(4);
    end
  endtask

  task automatic do_load(input logic [3:0] v);
    din = v; load_n = 1'b0; idle(1); load_n = 1'b1; idle(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd1977));
    idle(3);
    // R1: reset value observed right after release
    rst_n = 1'b1;
    idle(2);
    // R2: plain up counting
    pulse(3);
    // R4: wrap upward from 14
    do_load(4'd14); pulse(3);
    // R3 and R4: down counting through zero
    dir = 1'b1; do_load(4'd1); pulse(3);
    // R8: sit at terminal count with count clock low, then high
    do_load(4'd0); cnt_clk = 1'b1; idle(4); cnt_clk = 1'b0; idle(2);
    // R6: hold with enable high, then resume
    en_n = 1'b1; pulse(4); en_n = 1'b0; pulse(2);
    // R5: load on the same cycle a fall is seen
    dir = 1'b0; do_load(4'd7);
    cnt_clk = 1'b1; idle(4); cnt_clk = 1'b0; idle(2);
    din = 4'd9; load_n = 1'b0; idle(1); load_n = 1'b1; idle(4);
    // Random phase
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(2) == 0) cnt_clk = ~cnt_clk;
      if ($urandom_range(11) == 0) dir = ~dir;
      if ($urandom_range(9) == 0) en_n = ~en_n;
      load_n = ($urandom_range(19) != 0);
      din = 4'($urandom_range(15));
      idle(1);
    end
    load_n = 1'b1;
    idle(5);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end
endmodule